// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single-beat requests from inside the chip into accesses on an external memory-style bus whose address and data travel over one shared set of sixteen pins. Each access opens with an address phase, marked by a high address-latch strobe, in which the controller drives the address onto the shared pins. A data phase follows, with chip select low and either the read or the write strobe low. A hold phase then keeps chip select low after the strobe has ended.

All bus timing is counted in periods of a slower base clock, derived from the system clock by a programmable divider. The length of the address phase, the strobe and the hold is set by configuration inputs. The external data width is 8 or 16 bits. Separate idle gaps, during which chip select is high, can be programmed for three cases: after a write, between two reads, and between a read and a following write.

The requester raises `req_valid` with a stable address, direction, size and write data, and keeps them stable until `req_ready` pulses. Configuration inputs change only while no request is outstanding.

Top module: `mux_bus_ctrl`

## Requirements
- R1: The address phase lasts (cfg_t_ale+1)*(cfg_div+1) system clocks, with `bus_ale` high, `bus_ad_oe` high and both strobes high. The shared pins carry req_addr[15:0] in 8-bit mode, or the halfword address req_addr[16:1] in 16-bit mode.
- R2: Right after the address phase, one strobe (`bus_rd_n` for reads, `bus_wr_n` for writes) is low for (cfg_t_acc+1)*(cfg_div+1) clocks. It is followed by a hold of (cfg_t_ahd+1)*(cfg_div+1) clocks in which chip select stays low and both strobes are high.
- R3: During the strobe and the hold of a write, `bus_ad_oe` is high and the pins carry the write data. In 8-bit mode this is {8'h00, wdata[7:0]}. In 16-bit mode it is the whole halfword when req_half=1, and wdata[7:0] on both bytes when req_half=0.
- R4: During a read, `bus_ad_oe` is low while `bus_rd_n` is low, and `bus_ad_i` is sampled on the last clock of the strobe. `req_rdata` is {8'h00, pins[7:0]} in 8-bit mode and pins[15:0] for a 16-bit halfword. For a 16-bit byte it is {8'h00, pins[15:8]} when req_addr[0]=1 and {8'h00, pins[7:0]} when req_addr[0]=0.
- R5: While chip select is low, the active-low lane enables `bus_bl_n` (bit 0 = low byte, bit 1 = high byte) are 2'b10 in 8-bit mode and 2'b00 for a 16-bit halfword. For a 16-bit byte they are 2'b01 when req_addr[0]=1 and 2'b10 when req_addr[0]=0.
- R6: `req_ready` is high for exactly one clock, the last clock of the hold, and `req_rdata` is valid in that clock.
- R7: While chip select is high, `bus_ale` is low, both strobes are high, `bus_ad_oe` is low and `bus_bl_n` is 2'b11.
- R8: When a new request is already waiting as a write completes, chip select stays high for (cfg_idle_w2x+1)*(cfg_div+1) clocks before the next access, whatever type that access is.
- R9: When a read follows a read back to back, chip select stays high for (cfg_idle_r2r+1)*(cfg_div+1) clocks.
- R10: When a write follows a read back to back, chip select stays high for (cfg_idle_r2w+1)*(cfg_div+1) clocks.
- R11: While reset is held and after it is released with no request, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, and `bus_ale`, `bus_ad_oe` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | 1 selects the 16-bit external data width |
| cfg_div | input | DIV_W | Base clock period minus one, in system clocks |
| cfg_t_ale | input | CNT_W | Address phase length minus one, in base periods |
| cfg_t_acc | input | CNT_W | Strobe length minus one, in base periods |
| cfg_t_ahd | input | CNT_W | Hold length minus one, in base periods |
| cfg_idle_w2x | input | CNT_W | Idle periods after a write |
| cfg_idle_r2r | input | CNT_W | Idle periods between two reads |
| cfg_idle_r2w | input | CNT_W | Idle periods between a read and a write |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_half | input | 1 | 1 for a halfword, 0 for a byte (16-bit mode only) |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read data, valid with req_ready |
| bus_ad_o | output | 16 | Shared address/data pins, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared pins |
| bus_ad_i | input | 16 | Shared address/data pins, incoming value |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bl_n | output | 2 | Byte lane enables, active low |

## Verification
A phase counter that is off by one, or a divider that ticks at the wrong rate, shows up in the same access as a wrong high or low run length on `bus_ale`, the strobes or chip select. For this reason every run is measured in system clocks against the configured products. A stale last-access flag, or a wrong choice among the three idle counts, appears only as the chip-select high time before the following access, so accesses are chained back to back in every order of reads and writes. A capture on the wrong clock or the wrong byte lane shows as wrong data in the clock where `req_ready` is high, because the responder returns zero whenever the read strobe is high.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int DIV_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_t_ale,
  input  logic [CNT_W-1:0] cfg_t_acc,
  input  logic [CNT_W-1:0] cfg_t_ahd,
  input  logic [CNT_W-1:0] cfg_idle_w2x,
  input  logic [CNT_W-1:0] cfg_idle_r2r,
  input  logic [CNT_W-1:0] cfg_idle_r2w,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_half,
  input  logic [16:0]      req_addr,
  input  logic [15:0]      req_wdata,
  output logic             req_ready,
  output logic [15:0]      req_rdata,
  output logic [15:0]      bus_ad_o,
  output logic             bus_ad_oe,
  input  logic [15:0]      bus_ad_i,
  output logic             bus_ale,
  output logic             bus_cs_n,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic [1:0]       bus_bl_n
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_ALE, S_ACC, S_HOLD} st_t;

  st_t              st_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_rd_q;
  logic             gap_go_q;

  logic             tick, last, act, data_ph;
  logic [CNT_W-1:0] gap_sel;
  logic [15:0]      addr_bus, wd_bus, rd_fmt;
  logic [1:0]       lane_n;

  assign tick    = div_q >= cfg_div;
  assign last    = cnt_q == '0;
  assign gap_sel = req_write ? cfg_idle_r2w : cfg_idle_r2r;
  assign act     = st_q == S_ALE || st_q == S_ACC || st_q == S_HOLD;
  assign data_ph = st_q == S_ACC || st_q == S_HOLD;

  assign addr_bus = cfg_wide ? req_addr[16:1] : req_addr[15:0];
  assign wd_bus   = !cfg_wide ? {8'h00, req_wdata[7:0]} :
                    req_half  ? req_wdata : {2{req_wdata[7:0]}};
  assign rd_fmt   = !cfg_wide    ? {8'h00, bus_ad_i[7:0]} :
                    req_half     ? bus_ad_i :
                    req_addr[0]  ? {8'h00, bus_ad_i[15:8]} : {8'h00, bus_ad_i[7:0]};
  assign lane_n   = !cfg_wide ? 2'b10 : req_half ? 2'b00 : req_addr[0] ? 2'b01 : 2'b10;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
      gap_go_q  <= 1'b0;
      req_rdata <= '0;
    end else if (tick) begin
      case (st_q)
        S_IDLE:
          if (req_valid) begin
            if (last_rd_q && gap_sel != '0) begin
              st_q     <= S_GAP;
              cnt_q    <= gap_sel - 1'b1;
              gap_go_q <= 1'b1;
            end else begin
              st_q  <= S_ALE;
              cnt_q <= cfg_t_ale;
            end
          end
        S_GAP:
          if (!last) cnt_q <= cnt_q - 1'b1;
          else if (gap_go_q) begin
            st_q  <= S_ALE;
            cnt_q <= cfg_t_ale;
          end else st_q <= S_IDLE;
        S_ALE:
          if (!last) cnt_q <= cnt_q - 1'b1;
          else begin
            st_q  <= S_ACC;
            cnt_q <= cfg_t_acc;
          end
        S_ACC:
          if (!last) cnt_q <= cnt_q - 1'b1;
          else begin
            st_q  <= S_HOLD;
            cnt_q <= cfg_t_ahd;
            if (!req_write) req_rdata <= rd_fmt;
          end
        S_HOLD:
          if (!last) cnt_q <= cnt_q - 1'b1;
          else begin
            last_rd_q <= !req_write;
            if (req_write && cfg_idle_w2x != '0) begin
              st_q     <= S_GAP;
              cnt_q    <= cfg_idle_w2x - 1'b1;
              gap_go_q <= 1'b0;
            end else st_q <= S_IDLE;
          end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = tick && st_q == S_HOLD && last;
  assign bus_cs_n  = !act;
  assign bus_ale   = st_q == S_ALE;
  assign bus_rd_n  = !(st_q == S_ACC && !req_write);
  assign bus_wr_n  = !(st_q == S_ACC && req_write);
  assign bus_ad_oe = bus_ale || (data_ph && req_write);
  assign bus_ad_o  = bus_ale ? addr_bus : (data_ph && req_write) ? wd_bus : 16'h0000;
  assign bus_bl_n  = act ? lane_n : 2'b11;

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> bus_rd_n && bus_wr_n && bus_ad_oe); // R1
  AST_ALE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale && $past(bus_ale) |-> $stable(bus_ad_o)); // R1
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (!bus_rd_n || !bus_wr_n)); // R2
  AST_HOLD_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> !bus_cs_n); // R2
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n || bus_wr_n); // R2
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && bus_bl_n == 2'b11); // R7

endmodule

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/100ps
module test_mux_bus_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        cfg_wide;
  logic [3:0]  cfg_div, cfg_t_ale, cfg_t_acc, cfg_t_ahd;
  logic [3:0]  cfg_idle_w2x, cfg_idle_r2r, cfg_idle_r2w;
  logic        req_valid, req_write, req_half;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic [15:0] req_rdata, bus_ad_o, bus_ad_i;
  logic        bus_ad_oe, bus_ale, bus_cs_n, bus_rd_n, bus_wr_n;
  logic [1:0]  bus_bl_n;

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_div(cfg_div),
    .cfg_t_ale(cfg_t_ale), .cfg_t_acc(cfg_t_acc), .cfg_t_ahd(cfg_t_ahd),
    .cfg_idle_w2x(cfg_idle_w2x), .cfg_idle_r2r(cfg_idle_r2r), .cfg_idle_r2w(cfg_idle_r2w),
    .req_valid(req_valid), .req_write(req_write), .req_half(req_half),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_ale(bus_ale),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_bl_n(bus_bl_n));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  // Bus responder and pin monitor
  logic [15:0] lat_a = '0;
  assign bus_ad_i = !bus_rd_n ? pat(lat_a) : 16'h0000;

  int hi_run = 0, m_gap = 0, m_ale = 0, m_acc = 0, m_hold = 0, m_rdy = 0;
  int m_rd_oe = 0, m_wr_oe_bad = 0, idle_bad = 0;
  logic [15:0] m_addr = '0, m_wd = '0;
  logic [1:0]  m_bl = '0;
  bit cs_prev = 1'b1;

  always @(negedge clk) if (rst_n) begin
    if (!bus_cs_n) begin
      if (cs_prev) begin
        m_gap = hi_run; hi_run = 0;
        m_ale = 0; m_acc = 0; m_hold = 0; m_rdy = 0; m_rd_oe = 0; m_wr_oe_bad = 0;
      end
      if (bus_ale) begin
        m_ale++; m_addr = bus_ad_o; lat_a = bus_ad_o;
      end else begin
        if (!bus_rd_n || !bus_wr_n) begin
          m_acc++; m_bl = bus_bl_n;
          if (!bus_wr_n) m_wd = bus_ad_o;
          if (!bus_rd_n && bus_ad_oe) m_rd_oe++;
        end else m_hold++;
        if (req_write && !bus_ad_oe) m_wr_oe_bad++;
      end
      if (req_ready) m_rdy++;
      cs_prev = 1'b0;
    end else begin
      hi_run++; cs_prev = 1'b1;
      if (bus_ale || !bus_rd_n || !bus_wr_n || bus_ad_oe || bus_bl_n != 2'b11) idle_bad++;
    end
  end

  bit hung = 1'b0;

  task automatic access(input logic wide, input logic [2:0] dv, input logic [1:0] ta, tc, th,
                        input logic wr, hf, input logic [16:0] ad, input logic [15:0] wd,
                        input int expgap, input string gtag);
    int p, n;
    logic [15:0] ea, ed, er;
    logic [1:0]  el;
    cfg_wide = wide; cfg_div = {1'b0, dv};
    cfg_t_ale = {2'b00, ta}; cfg_t_acc = {2'b00, tc}; cfg_t_ahd = {2'b00, th};
    req_write = wr; req_half = hf; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 5000);
    if (!req_ready) hung = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    p  = int'(dv) + 1;
    ea = wide ? ad[16:1] : ad[15:0];
    ed = !wide ? {8'h00, wd[7:0]} : hf ? wd : {2{wd[7:0]}};
    er = !wide ? {8'h00, pat(ea)[7:0]} : hf ? pat(ea) :
         ad[0] ? {8'h00, pat(ea)[15:8]} : {8'h00, pat(ea)[7:0]};
    el = !wide ? 2'b10 : hf ? 2'b00 : ad[0] ? 2'b01 : 2'b10;
    chk(m_ale == (int'(ta) + 1) * p, "R1", "ale length", m_ale, (int'(ta) + 1) * p);
    chk(m_addr == ea, "R1", "address on pins", m_addr, ea);
    chk(m_acc == (int'(tc) + 1) * p, "R2", "strobe length", m_acc, (int'(tc) + 1) * p);
    chk(m_hold == (int'(th) + 1) * p, "R2", "hold length", m_hold, (int'(th) + 1) * p);
    chk(m_bl == el, "R5", "lane enables", m_bl, el);
    chk(m_rdy == 1, "R6", "ready clocks", m_rdy, 1);
    if (wr) begin
      chk(m_wd == ed, "R3", "write data", m_wd, ed);
      chk(m_wr_oe_bad == 0, "R3", "oe low in write data phase", m_wr_oe_bad, 0);
    end else begin
      chk(req_rdata == er, "R4", "read data", req_rdata, er);
      chk(m_rd_oe == 0, "R4", "oe high during read strobe", m_rd_oe, 0);
    end
    if (expgap >= 0) chk(m_gap == expgap, gtag, "idle gap", m_gap, expgap);
  endtask

  // wide, div, t_ale, t_acc, t_ahd, write, half, addr, wdata
  localparam logic [44:0] VEC [10] = '{
    {1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 17'h00012, 16'h0055},
    {1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 17'h01234, 16'h0000},
    {1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 17'h0FFFF, 16'h0000},
    {1'b0, 3'd0, 2'd1, 2'd0, 2'd2, 1'b1, 1'b0, 17'h00100, 16'h00AB},
    {1'b1, 3'd2, 2'd1, 2'd2, 2'd1, 1'b1, 1'b1, 17'h1FFFE, 16'hBEEF},
    {1'b1, 3'd2, 2'd1, 2'd2, 2'd1, 1'b0, 1'b1, 17'h00246, 16'h0000},
    {1'b1, 3'd2, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 17'h00247, 16'h0000},
    {1'b1, 3'd2, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 17'h00011, 16'h007E},
    {1'b1, 3'd1, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 17'h00010, 16'h0000},
    {1'b0, 3'd3, 2'd2, 2'd1, 2'd2, 1'b0, 1'b1, 17'h00ABC, 16'h0000}
  };

  task automatic finish_run();
    if (hung) chk(1'b0, "R6", "request never completed", 0, 1);
    chk(idle_bad == 0, "R7", "activity while deselected", idle_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int prev_div;
    bit prev_wr;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_half = 1'b0;
    req_addr = '0; req_wdata = '0; cfg_wide = 1'b0; cfg_div = '0;
    cfg_t_ale = '0; cfg_t_acc = '0; cfg_t_ahd = '0;
    cfg_idle_w2x = 4'd2; cfg_idle_r2r = 4'd1; cfg_idle_r2w = 4'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe && !req_ready, "R11",
        "pins during reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe, req_ready}, 6'b111000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe && !req_ready, "R11",
        "pins idle after reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe, req_ready}, 6'b111000);
    #1;

    prev_div = -1; prev_wr = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [44:0] v;
      int g, eg;
      string t;
      v = VEC[i];
      if (prev_wr) begin g = 2; t = "R8"; end
      else if (v[34]) begin g = 3; t = "R10"; end
      else begin g = 1; t = "R9"; end
      eg = (int'(v[43:41]) == prev_div) ? (g + 1) * (int'(v[43:41]) + 1) : -1;
      access(v[44], v[43:41], v[40:39], v[38:37], v[36:35], v[34], v[33], v[32:16], v[15:0], eg, t);
      prev_div = int'(v[43:41]); prev_wr = v[34];
      if (hung) finish_run();
    end

    // Zero idle counts: chip select high for exactly one base period
    cfg_idle_w2x = 4'd0; cfg_idle_r2r = 4'd0; cfg_idle_r2w = 4'd0;
    access(1'b1, 3'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 17'h00020, 16'h1357, -1, "R8");
    access(1'b1, 3'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 17'h00021, 16'h00C4, 2, "R8");
    access(1'b1, 3'd1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 17'h00020, 16'h0000, 2, "R8");
    access(1'b1, 3'd1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 17'h00021, 16'h0000, 2, "R9");
    access(1'b1, 3'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 17'h00030, 16'h2468, 2, "R10");

    // Largest read-to-read gap with a slow base clock
    cfg_idle_r2r = 4'd15;
    access(1'b0, 3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 17'h00007, 16'h0000, -1, "R9");
    access(1'b0, 3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 17'h00008, 16'h0000, 16 * 5, "R9");

    repeat (4) @(negedge clk);
    chk(!req_ready && bus_cs_n, "R6", "no ready without request", {req_ready, bus_cs_n}, 2'b01);
    finish_run();
  end
endmodule